// File: doc/BRIEF.md
# Interrupt Pending and Take Logic

This block keeps a set of eight interrupt-pending flags for a processor core and decides, every cycle, whether the core should enter its interrupt handler. Other logic in the core raises or drops single flags by level number. A single strobe wipes all of them at once. The block also watches a free-running counter and its compare value. When the two meet, it raises the flag whose number a small programmable selector names.

The take decision combines three things: the flags, a per-level enable mask, and three status inputs. The status inputs are a global enable, an error-level indicator and an exception-level indicator. Any request that names a level outside the implemented range changes no flag. Instead it sets a sticky error indicator, which only reset clears.

Top module: `irq_pend_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pend` becomes all zeros and `req_err` becomes 0. With `pend` zero, `take_irq` is 0.
- R2: With `post_vld` high and `post_lvl` = n below 8, bit n of `pend` is 1 after the next clock edge. Every other bit keeps its value unless another request in the same cycle targets it.
- R3: With `clr_vld` high and `clr_lvl` = n below 8, bit n of `pend` is 0 after the next clock edge, provided no post or timer set targets bit n. Every other bit keeps its value.
- R4: A post and a clear that name the same level in the same cycle leave that bit at 1.
- R5: With `clr_all` high, every bit of `pend` is 0 after the next clock edge, except the bits that a post or a timer set in the same cycle sets. Those bits are 1.
- R6: When `tmr_cmp` equals `tmr_count` and `tmr_count` is nonzero, bit `tmr_line` of `pend` is 1 after the next clock edge. This holds even if a clear or a clear-all in the same cycle targets that bit.
- R7: When `tmr_count` is zero, the timer sets no bit, even if `tmr_cmp` is also zero.
- R8: `take_irq` is high in the same cycle exactly when `glob_en` is 1, `err_lvl` is 0, `exc_lvl` is 0, and some bit is 1 in both `irq_mask` and `pend`.
- R9: A post or clear whose level is 8 or more leaves `pend` unchanged. It sets `req_err` to 1 at the next edge, and `req_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| post_vld | input | 1 | Post request strobe |
| post_lvl | input | 4 | Level number to set |
| clr_vld | input | 1 | Clear request strobe |
| clr_lvl | input | 4 | Level number to clear |
| clr_all | input | 1 | Drop every pending flag |
| glob_en | input | 1 | Global interrupt enable |
| err_lvl | input | 1 | Error level active (blocks take) |
| exc_lvl | input | 1 | Exception level active (blocks take) |
| irq_mask | input | 8 | Per-level enable mask |
| tmr_count | input | 32 | Running counter value |
| tmr_cmp | input | 32 | Compare value |
| tmr_line | input | 3 | Flag number raised by a timer match |
| pend | output | 8 | Pending flags |
| take_irq | output | 1 | Core should take an interrupt |
| req_err | output | 1 | Sticky out-of-range request flag |

## Verification
The clear paths and the set paths can hit the same flag in one cycle. Three such collisions matter: a post against a clear of the same level, a timer match against a clear of the selected level, and a timer match or post against a clear-all. The bench drives each collision in a single cycle. At mid-cycle after the edge, it compares `pend` against a model that applies the clears first and the sets second. The model expects the contested bit to read 1 and every untouched bit to keep its value.

// File: rtl/irq_pend_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and width helpers for the interrupt pending block.
// Assumes the level count is a power of two.
package irq_pend_pkg;
    localparam int unsigned DEF_NUM_LVL = 8;
    localparam int unsigned DEF_CNT_W   = 32;
    localparam int unsigned NUM_REQ_CH  = 2;  // channel 0 = post, channel 1 = clear

    // Request index width: one extra bit so out-of-range levels can be named.
    function automatic int unsigned req_idx_w(input int unsigned n);
        return $clog2(n) + 1;
    endfunction

    // Selector width for an in-range level.
    function automatic int unsigned sel_w(input int unsigned n);
        return $clog2(n);
    endfunction
endpackage

// File: rtl/irq_req_decode.sv
`timescale 1ns/1ps
// Module: irq_req_decode
// Turns a level-number request into a one-hot bit vector. It flags a
// request whose level lies at or beyond NUM_LVL. Purely combinational.
// Assumes IDX_W is wide enough to hold NUM_LVL.
module irq_req_decode #(
    parameter int unsigned NUM_LVL = 8,
    parameter int unsigned IDX_W   = 4
) (
    input  logic               vld,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_LVL-1:0] onehot,
    output logic               bad
);
    // Out-of-range detection: a valid request past the last level.
    assign bad = vld && (idx >= IDX_W'(NUM_LVL));

    // One comparator per level drives the one-hot output.
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_bit
        assign onehot[i] = vld && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/irq_tmr_match.sv
`timescale 1ns/1ps
// Module: irq_tmr_match
// Compares the running counter with its compare value. On a match with
// a nonzero counter, it raises the flag named by the selector.
// Combinational; the result is captured by the pending register.
module irq_tmr_match #(
    parameter int unsigned NUM_LVL = 8,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned SEL_W   = 3
) (
    input  logic [CNT_W-1:0]   count,
    input  logic [CNT_W-1:0]   cmp,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_LVL-1:0] set_vec
);
    logic hit;

    // Match condition: equal values, counter not at zero.
    assign hit = (count == cmp) && (count != '0);

    // Route the hit to the selected flag.
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_route
        assign set_vec[i] = hit && (sel == SEL_W'(i));
    end
endmodule

// File: rtl/irq_pend_reg.sv
`timescale 1ns/1ps
// Module: irq_pend_reg
// Holds the pending flags and the sticky request-error flag.
// Each cycle's update runs in a fixed order: clear-all, then single
// clears, then posts and timer sets. Sets therefore win any collision.
module irq_pend_reg #(
    parameter int unsigned NUM_LVL = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_all,
    input  logic [NUM_LVL-1:0] clr_vec,
    input  logic [NUM_LVL-1:0] set_vec,
    input  logic               bad_req,
    output logic [NUM_LVL-1:0] pend,
    output logic               err
);
    logic [NUM_LVL-1:0] pend_q, pend_d, base;
    logic               err_q;

    // Next-state of the flags: wipe, drop, then raise.
    always_comb begin
        base   = clr_all ? '0 : pend_q;
        base   = base & ~clr_vec;
        pend_d = base | set_vec;
    end

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // Sticky error: set by any out-of-range request, cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (bad_req) err_q <= 1'b1;
    end

    assign pend = pend_q;
    assign err  = err_q;
endmodule

// File: rtl/irq_take_gate.sv
`timescale 1ns/1ps
// Module: irq_take_gate
// Decides whether the core takes an interrupt. An enabled pending flag
// is needed, and the status inputs must allow it. Combinational.
module irq_take_gate #(
    parameter int unsigned NUM_LVL = 8
) (
    input  logic               glob_en,
    input  logic               err_lvl,
    input  logic               exc_lvl,
    input  logic [NUM_LVL-1:0] mask,
    input  logic [NUM_LVL-1:0] pend,
    output logic               take
);
    logic allowed;
    logic any_live;

    // Status gate: enabled and neither error nor exception level active.
    assign allowed  = glob_en && !err_lvl && !exc_lvl;
    // Per-level AND, then OR-reduce.
    assign any_live = |(mask & pend);
    assign take     = allowed && any_live;
endmodule

// File: rtl/irq_pend_top.sv
`timescale 1ns/1ps
// Module: irq_pend_top
// Top of the interrupt pending block. It decodes the post and clear
// requests and merges in the timer match. It registers the flags and
// gates the take decision. Assumes NUM_LVL is a power of two.
module irq_pend_top
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_LVL = DEF_NUM_LVL,
    parameter int unsigned CNT_W   = DEF_CNT_W,
    localparam int unsigned REQ_W  = req_idx_w(NUM_LVL),
    localparam int unsigned SEL_W  = sel_w(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_vld,
    input  logic [REQ_W-1:0]   post_lvl,
    input  logic               clr_vld,
    input  logic [REQ_W-1:0]   clr_lvl,
    input  logic               clr_all,
    input  logic               glob_en,
    input  logic               err_lvl,
    input  logic               exc_lvl,
    input  logic [NUM_LVL-1:0] irq_mask,
    input  logic [CNT_W-1:0]   tmr_count,
    input  logic [CNT_W-1:0]   tmr_cmp,
    input  logic [SEL_W-1:0]   tmr_line,
    output logic [NUM_LVL-1:0] pend,
    output logic               take_irq,
    output logic               req_err
);
    logic               ch_vld [NUM_REQ_CH];
    logic [REQ_W-1:0]   ch_idx [NUM_REQ_CH];
    logic [NUM_LVL-1:0] ch_oh  [NUM_REQ_CH];
    logic               ch_bad [NUM_REQ_CH];
    logic [NUM_LVL-1:0] tmr_vec;
    logic [NUM_LVL-1:0] set_all;

    assign ch_vld[0] = post_vld;
    assign ch_idx[0] = post_lvl;
    assign ch_vld[1] = clr_vld;
    assign ch_idx[1] = clr_lvl;

    // One decoder per request channel.
    for (genvar c = 0; c < NUM_REQ_CH; c++) begin : g_ch
        irq_req_decode #(.NUM_LVL(NUM_LVL), .IDX_W(REQ_W)) u_dec (
            .vld   (ch_vld[c]),
            .idx   (ch_idx[c]),
            .onehot(ch_oh[c]),
            .bad   (ch_bad[c])
        );
    end

    irq_tmr_match #(.NUM_LVL(NUM_LVL), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_tmr (
        .count  (tmr_count),
        .cmp    (tmr_cmp),
        .sel    (tmr_line),
        .set_vec(tmr_vec)
    );

    // Posts and the timer both feed the set side.
    assign set_all = ch_oh[0] | tmr_vec;

    irq_pend_reg #(.NUM_LVL(NUM_LVL)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_all(clr_all),
        .clr_vec(ch_oh[1]),
        .set_vec(set_all),
        .bad_req(ch_bad[0] || ch_bad[1]),
        .pend   (pend),
        .err    (req_err)
    );

    irq_take_gate #(.NUM_LVL(NUM_LVL)) u_take (
        .glob_en(glob_en),
        .err_lvl(err_lvl),
        .exc_lvl(exc_lvl),
        .mask   (irq_mask),
        .pend   (pend),
        .take   (take_irq)
    );
endmodule

// File: rtl/irq_pend_chk.sv
`timescale 1ns/1ps
// Module: irq_pend_chk
// Property checker for irq_pend_top, attached through bind. It builds
// its own request masks from the ports and relates them over time.
module irq_pend_chk #(
    parameter int unsigned NUM_LVL = 8,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned REQ_W   = 4,
    parameter int unsigned SEL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               post_vld,
    input logic [REQ_W-1:0]   post_lvl,
    input logic               clr_vld,
    input logic [REQ_W-1:0]   clr_lvl,
    input logic               clr_all,
    input logic               glob_en,
    input logic               err_lvl,
    input logic               exc_lvl,
    input logic [NUM_LVL-1:0] irq_mask,
    input logic [CNT_W-1:0]   tmr_count,
    input logic [CNT_W-1:0]   tmr_cmp,
    input logic [SEL_W-1:0]   tmr_line,
    input logic [NUM_LVL-1:0] pend,
    input logic               take_irq,
    input logic               req_err
);
    logic               post_ok, clr_ok, tmr_hit, bad_any;
    logic [NUM_LVL-1:0] post_m, clr_m, tmr_m;

    // Checker-side request decoding.
    always_comb begin
        post_ok = post_vld && (post_lvl < REQ_W'(NUM_LVL));
        clr_ok  = clr_vld && (clr_lvl < REQ_W'(NUM_LVL));
        tmr_hit = (tmr_count == tmr_cmp) && (tmr_count != '0);
        post_m  = post_ok ? (NUM_LVL'(1) << post_lvl) : '0;
        clr_m   = clr_ok  ? (NUM_LVL'(1) << clr_lvl)  : '0;
        tmr_m   = tmr_hit ? (NUM_LVL'(1) << tmr_line) : '0;
        bad_any = (post_vld && !post_ok) || (clr_vld && !clr_ok);
    end

    // R2
    post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_ok |=> ((pend & $past(post_m)) == $past(post_m)));

    // R3
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ok && !post_vld && !clr_all && !tmr_hit) |=> (pend == ($past(pend) & ~$past(clr_m))));

    // R5
    wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !post_vld && !tmr_hit) |=> (pend == '0));

    // R6
    tmr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_hit |=> ((pend & $past(tmr_m)) == $past(tmr_m)));

    // R8
    take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq == (glob_en && !err_lvl && !exc_lvl && ((irq_mask & pend) != '0)));

    // R9
    bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_any |=> req_err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> req_err);

    // R9
    bad_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_any && !post_ok && !clr_ok && !clr_all && !tmr_hit) |=> $stable(pend));
endmodule

bind irq_pend_top irq_pend_chk #(
    .NUM_LVL(NUM_LVL), .CNT_W(CNT_W), .REQ_W(REQ_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_lvl(post_lvl),
    .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_all(clr_all),
    .glob_en(glob_en), .err_lvl(err_lvl), .exc_lvl(exc_lvl),
    .irq_mask(irq_mask), .tmr_count(tmr_count), .tmr_cmp(tmr_cmp),
    .tmr_line(tmr_line), .pend(pend), .take_irq(take_irq), .req_err(req_err)
);

// File: tb/test_irq_pend_top.sv
`timescale 1ns/1ps
// Scoreboard bench for irq_pend_top. A driver task applies one cycle of
// requests, updates a reference model and queues the expected state.
// A monitor pops and compares at mid-cycle.
module test_irq_pend_top;
    typedef struct {
        logic [7:0] pend;
        logic       err;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_vld = 1'b0, clr_vld = 1'b0, clr_all = 1'b0;
    logic [3:0]  post_lvl = '0, clr_lvl = '0;
    logic        glob_en = 1'b0, err_lvl = 1'b0, exc_lvl = 1'b0;
    logic [7:0]  irq_mask = '0;
    logic [31:0] tmr_count = '0, tmr_cmp = 32'd1;
    logic [2:0]  tmr_line = '0;
    logic [7:0]  pend;
    logic        take_irq, req_err;

    exp_t        sb_q[$];
    logic [7:0]  m_pend = '0;
    logic        m_err = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    irq_pend_top i_irq_pend_top (
        .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_lvl(post_lvl),
        .clr_vld(clr_vld), .clr_lvl(clr_lvl), .clr_all(clr_all),
        .glob_en(glob_en), .err_lvl(err_lvl), .exc_lvl(exc_lvl),
        .irq_mask(irq_mask), .tmr_count(tmr_count), .tmr_cmp(tmr_cmp),
        .tmr_line(tmr_line), .pend(pend), .take_irq(take_irq), .req_err(req_err)
    );

    // Driver: one cycle of requests. Called just after a rising edge.
    task automatic step(input bit pv, input int pl, input bit cv, input int cl,
                        input bit ca, input int cnt, input int cmp, input int line,
                        input string tag);
        logic [7:0] nx;
        exp_t       e;
        post_vld = pv;  post_lvl = 4'(pl);
        clr_vld  = cv;  clr_lvl  = 4'(cl);
        clr_all  = ca;
        tmr_count = 32'(cnt);  tmr_cmp = 32'(cmp);  tmr_line = 3'(line);
        nx = ca ? 8'h00 : m_pend;
        if (cv && cl < 8) nx[cl] = 1'b0;
        if (pv && pl < 8) nx[pl] = 1'b1;
        if (cnt == cmp && cnt != 0) nx[line] = 1'b1;
        if ((pv && pl >= 8) || (cv && cl >= 8)) m_err = 1'b1;
        m_pend = nx;
        @(posedge clk);
        #1;
        e.pend = m_pend;  e.err = m_err;  e.tag = tag;
        sb_q.push_back(e);
        post_vld = 1'b0;  clr_vld = 1'b0;  clr_all = 1'b0;
        tmr_count = '0;   tmr_cmp = 32'd1;
    endtask

    // Monitor: compare the queued expectation at mid-cycle.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (pend !== e.pend || req_err !== e.err) begin
                n_fail++;
                $display("FAIL %s: pend=%h err=%b expected pend=%h err=%b",
                         e.tag, pend, req_err, e.pend, e.err);
            end
        end
    end

    // Direct check of the combinational take output.
    task automatic check_take(input bit en, input bit el, input bit xl,
                              input logic [7:0] msk, input string tag);
        logic exp_take;
        glob_en = en;  err_lvl = el;  exc_lvl = xl;  irq_mask = msk;
        #1;
        exp_take = en && !el && !xl && ((msk & m_pend) != 8'h00);
        n_chk++;
        if (take_irq !== exp_take) begin
            n_fail++;
            $display("FAIL %s: take=%b expected %b", tag, take_irq, exp_take);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (pend !== 8'h00 || req_err !== 1'b0 || take_irq !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: pend=%h err=%b take=%b expected 00 0 0", pend, req_err, take_irq);
        end
        rst_n = 1'b1;
        @(posedge clk);  #1;

        // R2: posts to several levels
        step(1, 0, 0, 0, 0, 0, 1, 0, "R2 post0");
        step(1, 3, 0, 0, 0, 0, 1, 0, "R2 post3");
        step(1, 7, 0, 0, 0, 0, 1, 0, "R2 post7");
        // R3: single clear
        step(0, 0, 1, 3, 0, 0, 1, 0, "R3 clear3");
        step(0, 0, 1, 6, 0, 0, 1, 0, "R3 clear idle bit6");
        // R4: post and clear collide on one level
        step(1, 5, 1, 5, 0, 0, 1, 0, "R4 collide5");
        step(1, 7, 1, 7, 0, 0, 1, 0, "R4 collide7 set");
        // R5: clear-all, alone and with a post
        step(0, 0, 0, 0, 1, 0, 1, 0, "R5 wipe");
        step(1, 2, 0, 0, 0, 0, 1, 0, "R2 post2");
        step(1, 1, 0, 0, 1, 0, 1, 0, "R5 wipe plus post1");
        // R6: timer match, with a clear and with clear-all
        step(0, 0, 0, 0, 0, 100, 100, 4, "R6 timer line4");
        step(0, 0, 1, 4, 0, 0, 1, 0, "R3 clear4");
        step(0, 0, 1, 4, 0, 55, 55, 4, "R6 timer vs clear4");
        step(0, 0, 0, 0, 1, 9, 9, 6, "R6 timer vs wipe");
        step(0, 0, 0, 0, 0, 9, 10, 2, "R6 no match");
        // R7: zero count never matches
        step(0, 0, 0, 0, 0, 0, 0, 3, "R7 zero count");

        // R8: take gating with pend = bit6 only
        check_take(1, 0, 0, 8'h40, "R8 enabled");
        check_take(1, 0, 1, 8'h40, "R8 exc level");
        check_take(1, 1, 0, 8'h40, "R8 err level");
        check_take(0, 0, 0, 8'h40, "R8 disabled");
        check_take(1, 0, 0, 8'hBF, "R8 masked");
        check_take(1, 0, 0, 8'hFF, "R8 all mask");

        // R9: out-of-range requests
        step(1, 9, 0, 0, 0, 0, 1, 0, "R9 post9");
        step(0, 0, 1, 12, 0, 0, 1, 0, "R9 clear12");
        step(1, 0, 0, 0, 0, 0, 1, 0, "R9 sticky after post0");
        step(0, 0, 1, 8, 0, 0, 1, 0, "R9 clear8");
        @(negedge clk);  #1;

        // R1: reset again drops the sticky error
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        n_chk++;
        if (pend !== 8'h00 || req_err !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 re-reset: pend=%h err=%b expected 00 0", pend, req_err);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule